// File: doc/BRIEF.md
# Enhancement Table Pixel Modifier

This block sits in a display pixel pipeline. It holds a small table of per-brightness enhancement factors and applies them to every RGB pixel that passes through. Software fills the table one entry at a time through a single data port. The port shares its function select with histogram readout, so the table only accepts data once the pipeline has crossed a vertical blank after software switched the select over to enhancement loading.

Each pixel's brightness is taken as the largest of its three colour channels. The brightness picks two neighbouring table entries, and the block blends between them to get a factor. That factor then scales every channel, or is added to every channel as an offset, depending on a mode input. Results clip to the 8-bit range. With the table disabled, pixels come out unchanged and arrive after the same number of cycles.

Top module: `enh_pixel_mod`

## Requirements
- R1: After reset, every one of the 33 table entries holds 512 (a factor of 1.0 in the format with 1 integer bit and 9 fraction bits), the write index is 0, out_valid is 0 and out_rgb is 0.
- R2: Writes are accepted only while func_ie is 1 and at least one vblank_tick has been seen since func_ie last rose. A write made before that vblank, or made while func_ie is 0, is dropped and leaves both the table and the index unchanged.
- R3: If func_ie has stayed at 1 across an earlier vblank_tick, no further vblank is needed: writes that follow an index reset are accepted at once.
- R4: Each accepted write stores wr_data at the current index and then increments the index. Once 33 entries have been written, further writes are ignored. idx_clr returns the index to 0, and when it is asserted together with wr_en, the write is dropped.
- R5: The brightness v is max(R,G,B), with R in pix_rgb[23:16], G in [15:8] and B in [7:0]. With k = v>>3 and t = v&7, the factor is f = (E[k]*(8-t) + E[k+1]*t)>>3.
- R6: When mode_add is 0, each output channel is (channel*f)>>9, clipped to 255.
- R7: When mode_add is 1, each output channel is channel + (f>>2), clipped to 255.
- R8: When table_en is 0, out_rgb equals the pix_rgb presented two cycles earlier.
- R9: out_valid is high exactly two cycles after pix_valid is high. table_en and mode_add are sampled along with the pixel.
- R10: Returning func_ie to 0 keeps the loaded table in use for pixels. Switching func_ie back to 1 again requires a new vblank before writes are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vblank_tick | input | 1 | One-cycle pulse at the start of vertical blank |
| func_ie | input | 1 | Data-port function: 1 = enhancement table load, 0 = histogram readout |
| idx_clr | input | 1 | Sets the write index back to 0 |
| wr_en | input | 1 | Write strobe for the data port |
| wr_data | input | 10 | Table entry value, 1.9 unsigned fixed point |
| mode_add | input | 1 | 0 = multiply by factor, 1 = add offset |
| table_en | input | 1 | 1 = apply table, 0 = pass through |
| pix_valid | input | 1 | Input pixel valid |
| pix_rgb | input | 24 | Input pixel {R,G,B} |
| out_valid | output | 1 | Output pixel valid |
| out_rgb | output | 24 | Output pixel {R,G,B} |

## Verification
A pixel presented at one clock edge shows up on out_rgb after the second edge that follows. The bench drives each pixel for one cycle, waits two falling edges and only then compares the result with its own interpolation model, so exactly two register stages lie between stimulus and sample. A write takes effect at the edge where it is sampled. Its effect is therefore never read directly: the bench sends a later pixel whose brightness selects the touched entries, and that pixel's output shows whether the write was stored or dropped. A vblank or a function switch is likewise seen one edge after it is driven, and the bench drives its next write only after that edge.

// File: rtl/enh_pixel_mod.sv
module enh_pixel_mod #(
  parameter int PW = 8,
  parameter int FW = 10,
  parameter int FRAC = 9,
  parameter int SB = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            vblank_tick,
  input  logic            func_ie,
  input  logic            idx_clr,
  input  logic            wr_en,
  input  logic [FW-1:0]   wr_data,
  input  logic            mode_add,
  input  logic            table_en,
  input  logic            pix_valid,
  input  logic [3*PW-1:0] pix_rgb,
  output logic            out_valid,
  output logic [3*PW-1:0] out_rgb
);
  localparam int NE = (1 << (PW - SB)) + 1;
  localparam int IW = $clog2(NE + 1);
  localparam int MW = FW + SB + 1;
  localparam logic [IW-1:0] NE_I = IW'(NE);
  localparam logic [FW-1:0] UNITY = FW'(1 << FRAC);
  localparam logic [PW-1:0] PMAX = {PW{1'b1}};

  logic [FW-1:0] tbl [NE];
  logic [IW-1:0] wr_idx;
  logic          ie_ready;
  logic          wr_ok;

  assign wr_ok = wr_en && func_ie && ie_ready && !idx_clr && (wr_idx < NE_I);

  always_ff @(posedge clk) begin
    if (!rst_n)           ie_ready <= 1'b0;
    else if (!func_ie)    ie_ready <= 1'b0;
    else if (vblank_tick) ie_ready <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_idx <= '0;
      for (int i = 0; i < NE; i++) tbl[i] <= UNITY;
    end else if (idx_clr) begin
      wr_idx <= '0;
    end else if (wr_ok) begin
      tbl[wr_idx] <= wr_data;
      wr_idx <= wr_idx + 1'b1;
    end
  end

  logic [PW-1:0] ch_r, ch_g, ch_b, vmax;
  assign ch_r = pix_rgb[3*PW-1 -: PW];
  assign ch_g = pix_rgb[2*PW-1 -: PW];
  assign ch_b = pix_rgb[PW-1 -: PW];
  assign vmax = (ch_r >= ch_g && ch_r >= ch_b) ? ch_r : (ch_g >= ch_b) ? ch_g : ch_b;

  logic [IW-1:0] lo_idx, hi_idx;
  logic [SB:0]   w_hi, w_lo;
  logic [MW-1:0] mix;
  logic [FW-1:0] blend;
  assign lo_idx = IW'(vmax >> SB);
  assign hi_idx = lo_idx + 1'b1;
  assign w_hi   = {1'b0, vmax[SB-1:0]};
  assign w_lo   = (SB+1)'(1 << SB) - w_hi;
  assign mix    = MW'(tbl[lo_idx]) * MW'(w_lo) + MW'(tbl[hi_idx]) * MW'(w_hi);
  assign blend  = mix[SB +: FW];

  logic            s1_valid, s1_en, s1_add;
  logic [3*PW-1:0] s1_rgb;
  logic [FW-1:0]   s1_f;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0; s1_en <= 1'b0; s1_add <= 1'b0;
      s1_rgb <= '0; s1_f <= '0;
    end else begin
      s1_valid <= pix_valid; s1_en <= table_en; s1_add <= mode_add;
      s1_rgb <= pix_rgb; s1_f <= blend;
    end
  end

  function automatic logic [PW-1:0] shade(input logic [PW-1:0] ch, input logic [FW-1:0] f,
                                          input logic add);
    logic [PW+FW-1:0] prod;
    logic [PW:0]      sum;
    prod = ((PW+FW)'(ch) * (PW+FW)'(f)) >> FRAC;
    sum  = {1'b0, ch} + {1'b0, f[FW-1 -: PW]};
    if (add) return sum[PW] ? PMAX : sum[PW-1:0];
    return (|prod[PW+FW-1:PW]) ? PMAX : prod[PW-1:0];
  endfunction

  logic [3*PW-1:0] s2_rgb;
  for (genvar c = 0; c < 3; c++) begin : g_chan
    assign s2_rgb[c*PW +: PW] = s1_en ? shade(s1_rgb[c*PW +: PW], s1_f, s1_add)
                                      : s1_rgb[c*PW +: PW];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0; out_rgb <= '0;
    end else begin
      out_valid <= s1_valid; out_rgb <= s2_rgb;
    end
  end

  p_idx_bound_r4: assert property (@(posedge clk) disable iff (!rst_n) wr_idx <= NE_I);
  p_drop_early_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ie_ready && !idx_clr) |=> $stable(wr_idx));
  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && func_ie && ie_ready && !idx_clr && wr_idx < NE_I) |=> wr_idx == $past(wr_idx) + 1'b1);
  p_tc_rearm_r10: assert property (@(posedge clk) disable iff (!rst_n) !func_ie |=> !ie_ready);
  p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n) pix_valid |-> ##2 out_valid);
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n) !pix_valid |-> ##2 !out_valid);
  p_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !table_en) |-> ##2 (out_rgb == $past(pix_rgb, 2)));
endmodule

// File: tb/enh_pixel_mod_tb_top.sv
module enh_pixel_mod_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic vblank_tick = 0, func_ie = 0, idx_clr = 0, wr_en = 0, mode_add = 0, table_en = 0, pix_valid = 0;
  logic [9:0]  wr_data = '0;
  logic [23:0] pix_rgb = '0;
  logic        out_valid;
  logic [23:0] out_rgb;

  always #10 clk = ~clk;

  enh_pixel_mod dut_i (.*);

  int errors = 0, checks = 0;
  int m_tbl [33];
  int m_idx = 0;
  bit m_ready = 0, m_func = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  function automatic int factor(input int v);
    int k = v >> 3, t = v & 7;
    return (m_tbl[k] * (8 - t) + m_tbl[k+1] * t) >> 3;
  endfunction

  function automatic int chan(input int c, input int f, input bit add, input bit en);
    int r;
    if (!en) return c;
    r = add ? c + (f >> 2) : (c * f) >> 9;
    return (r > 255) ? 255 : r;
  endfunction

  function automatic logic [23:0] expect_px(input logic [23:0] p, input bit add, input bit en);
    int r = p[23:16], g = p[15:8], b = p[7:0];
    int v = (r >= g && r >= b) ? r : (g >= b) ? g : b;
    int f = factor(v);
    return {8'(chan(r, f, add, en)), 8'(chan(g, f, add, en)), 8'(chan(b, f, add, en))};
  endfunction

  task automatic pix(input logic [23:0] p, input string req);
    logic [23:0] e = expect_px(p, mode_add, table_en);
    pix_valid = 1; pix_rgb = p;
    tick();
    pix_valid = 0;
    chk("R9 early", int'(out_valid), 0);
    tick();
    chk("R9 valid", int'(out_valid), 1);
    chk(req, int'(out_rgb), int'(e));
  endtask

  task automatic wr(input int v);
    wr_en = 1; wr_data = 10'(v);
    tick();
    wr_en = 0;
    if (m_func && m_ready && m_idx < 33) begin m_tbl[m_idx] = v; m_idx++; end
  endtask

  task automatic vbl(); vblank_tick = 1; tick(); vblank_tick = 0; if (m_func) m_ready = 1; endtask
  task automatic setf(input bit b); func_ie = b; tick(); m_func = b; if (!b) m_ready = 0; endtask
  task automatic clr(); idx_clr = 1; tick(); idx_clr = 0; m_idx = 0; endtask

  function automatic logic [23:0] rnd_px(); return 24'($urandom); endfunction

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 33; i++) m_tbl[i] = 512;
    repeat (3) tick();
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 out_rgb", int'(out_rgb), 0);
    rst_n = 1;
    tick();
    table_en = 1; mode_add = 0;
    pix(24'h80_40_20, "R1 unity table");
    pix(24'hFF_FF_FF, "R1 unity top entry");

    // R2: switch to load function, write before any vblank
    setf(1);
    clr();
    for (int i = 0; i < 5; i++) wr(0);
    pix(24'h10_08_04, "R2 early writes dropped");
    pix(24'h05_03_01, "R2 early writes dropped e0");

    // full load after a vblank, then overflow writes (R4)
    vbl();
    clr();
    for (int i = 0; i < 33; i++)
      wr((i >= 31) ? 1023 : (i <= 1) ? 0 : (i == 16) ? 512 : int'($urandom % 1024));
    chk("R4 model index", m_idx, 33);
    for (int i = 0; i < 3; i++) wr(7);
    pix(24'hFF_C8_64, "R4 overflow ignored, R6 saturation");
    pix(24'h03_02_01, "R5 bottom entries zero");
    pix(24'h80_80_80, "R5 mid entry");

    mode_add = 0;
    for (int n = 0; n < 40; n++) pix(rnd_px(), "R6 multiplicative");
    mode_add = 1;
    pix(24'hFF_C8_64, "R7 additive saturation");
    pix(24'h03_02_01, "R7 additive zero offset");
    for (int n = 0; n < 40; n++) pix(rnd_px(), "R7 additive");
    table_en = 0;
    for (int n = 0; n < 20; n++) pix(rnd_px(), "R8 bypass");
    table_en = 1; mode_add = 0;

    // R3: already armed, no new vblank needed; R4 index clear mid-write
    clr();
    wr(100); wr(200);
    clr();
    wr(300);
    for (int v = 0; v < 16; v += 3) pix({8'(v), 8'(v), 8'(v)}, "R3 R4 reload without vblank");
    clr();
    idx_clr = 1; wr_en = 1; wr_data = 10'd9;
    tick();
    idx_clr = 0; wr_en = 0; m_idx = 0;
    pix(24'h01_00_00, "R4 clear beats write");

    // R10: back to readout, table still applied, writes dropped, re-arm needed
    setf(0);
    clr();
    wr(1000);
    for (int n = 0; n < 10; n++) pix(rnd_px(), "R10 table kept in readout");
    setf(1);
    clr();
    wr(1000); wr(1000);
    pix(24'h04_00_00, "R10 no write before new vblank");
    vbl();
    clr();
    wr(1000); wr(1000);
    pix(24'h04_00_00, "R10 writes after vblank");
    for (int n = 0; n < 20; n++) pix(rnd_px(), "R5 final random");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule